// File: doc/BRIEF.md
# Keyed Expiry Reset Pulse Generator

This block turns a watchdog expiry event into an external reset pulse of programmable length. A single 32-bit configuration word sets the pulse length in microseconds, the level that counts as asserted, and whether the output is driven at all times (push-pull) or only while the pulse lasts (open-drain). A free-running 1 MHz tick sets the time base, so one width unit equals one tick period.

Output polarity and drive mode are guarded: the top byte of a configuration write works as a key. Four key values set or clear one of the two mode bits. Any other value leaves both mode bits as they were, but the width bits of that write are still stored. The pad is modelled by a level output and an output-enable; the pad cell is not part of the block.

Top module: `pg_expiry_pulse`

## Requirements
- R1: After reset the readback word is 0x000000FF: width 255, active-low polarity (bit 31 = 0), open-drain drive (bit 30 = 0). The output-enable is low and the level is 1.
- R2: Every write stores data bits 19:0 as the width. Readback returns the width in bits 19:0 and zeros in bits 29:20.
- R3: A write whose bits 31:24 hold 0xA5 makes the polarity active high (readback bit 31 = 1). The value 0x5A makes it active low (bit 31 = 0).
- R4: A write whose bits 31:24 hold 0xA8 selects push-pull (readback bit 30 = 1). The value 0x8A selects open-drain (bit 30 = 0).
- R5: A write with any other top-byte value leaves polarity and drive mode unchanged and still stores its width bits.
- R6: The pulse begins at the first tick after the clock edge that samples the expiry input, never at a tick in that same cycle.
- R7: With stored width N the pulse lasts exactly N+1 tick periods, so N = 0 gives one period.
- R8: An expiry that arrives while a pulse is waiting to start or is running is ignored. It neither lengthens the pulse nor starts a second one.
- R9: The width is captured when the pulse starts. A width write during a pulse affects only later pulses.
- R10: While the pulse is asserted the level output equals the polarity bit. At all other times it equals the inverse.
- R11: In push-pull mode the output-enable stays high. In open-drain mode it is high only while the pulse is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe, one cycle |
| cfg_wr_data | input | 32 | Write word: key in 31:24, width in 19:0 |
| cfg_rd_data | output | 32 | Readback: polarity 31, drive 30, width 19:0 |
| tick_1us | input | 1 | One-cycle time-base tick, 1 MHz |
| expire | input | 1 | Watchdog expiry trigger |
| rst_level | output | 1 | Reset pulse level toward the pad |
| rst_oe | output | 1 | Output-enable toward the pad |

## Verification
A wrong mode bit shows on the readback word in the cycle after the write. It also shows on the level or enable pins before any pulse, because the idle level and the open-drain enable depend on those bits. A wrong count or a wrong pending state first shows at a tick boundary. The pulse then starts or ends one tick period early or late, or a stray second pulse follows. The bench therefore compares both pins and the readback word with a behavioural model on every cycle. It also measures whole pulse lengths in clock cycles for several widths, with retriggers and width writes in the middle of a pulse.

// File: rtl/pg_pkg.sv
package pg_pkg;

  localparam int KEY_W = 8;

  localparam logic [KEY_W-1:0] KEY_POL_HIGH = 8'hA5;
  localparam logic [KEY_W-1:0] KEY_POL_LOW  = 8'h5A;
  localparam logic [KEY_W-1:0] KEY_DRV_PUSH = 8'hA8;
  localparam logic [KEY_W-1:0] KEY_DRV_OPEN = 8'h8A;

  typedef struct packed {
    logic pol_high;   // 1: asserted level is high
    logic push_pull;  // 1: always driven
  } out_mode_t;

  localparam out_mode_t MODE_RESET = '{pol_high: 1'b0, push_pull: 1'b0};

  // Key decode: only exact key values change a mode bit
  function automatic out_mode_t apply_key(input out_mode_t cur,
                                          input logic [KEY_W-1:0] key);
    out_mode_t nxt;
    nxt = cur;
    case (key)
      KEY_POL_HIGH: nxt.pol_high  = 1'b1;
      KEY_POL_LOW:  nxt.pol_high  = 1'b0;
      KEY_DRV_PUSH: nxt.push_pull = 1'b1;
      KEY_DRV_OPEN: nxt.push_pull = 1'b0;
      default:      nxt = cur;
    endcase
    return nxt;
  endfunction

  function automatic logic pad_level(input logic pol_high, input logic asserted);
    return asserted ? pol_high : ~pol_high;
  endfunction

  function automatic logic pad_enable(input logic push_pull, input logic asserted);
    return push_pull | asserted;
  endfunction

endpackage

// File: rtl/pg_cfg_reg.sv
module pg_cfg_reg
  import pg_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int WIDTH_BITS  = 20,
  parameter int RESET_WIDTH = 255
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [DATA_W-1:0]     wr_data,
  output logic [WIDTH_BITS-1:0] width_q,
  output out_mode_t             mode_q,
  output logic [DATA_W-1:0]     rd_data
);
  localparam int KEY_LSB = DATA_W - KEY_W;

  logic [KEY_W-1:0] key;
  logic             unused_mid;

  assign key        = wr_data[DATA_W-1 -: KEY_W];
  assign unused_mid = ^wr_data[KEY_LSB-1:WIDTH_BITS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      width_q <= WIDTH_BITS'(RESET_WIDTH);
      mode_q  <= MODE_RESET;
    end else if (wr_en) begin
      width_q <= wr_data[WIDTH_BITS-1:0];
      mode_q  <= apply_key(mode_q, key);
    end
  end

  always_comb begin
    rd_data                   = '0;
    rd_data[WIDTH_BITS-1:0]   = width_q;
    rd_data[DATA_W-1]         = mode_q.pol_high;
    rd_data[DATA_W-2]         = mode_q.push_pull;
  end

endmodule

// File: rtl/pg_pulse_timer.sv
module pg_pulse_timer #(
  parameter int WIDTH_BITS = 20
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  input  logic                  expire,
  input  logic [WIDTH_BITS-1:0] load_width,
  output logic                  active,
  output logic                  pending,
  output logic                  accept_evt,
  output logic                  start_evt,
  output logic                  end_evt
);
  logic [WIDTH_BITS-1:0] remaining;

  function automatic logic [WIDTH_BITS-1:0] step_down(input logic [WIDTH_BITS-1:0] v);
    return v - WIDTH_BITS'(1);
  endfunction

  assign accept_evt = expire & ~active & ~pending;
  assign start_evt  = pending & tick;
  assign end_evt    = active & tick & (remaining == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending   <= 1'b0;
      active    <= 1'b0;
      remaining <= '0;
    end else begin
      if (accept_evt)     pending <= 1'b1;
      else if (start_evt) pending <= 1'b0;

      if (start_evt) begin
        active    <= 1'b1;
        remaining <= load_width;
      end else if (end_evt) begin
        active    <= 1'b0;
      end else if (active && tick) begin
        remaining <= step_down(remaining);
      end
    end
  end

endmodule

// File: rtl/pg_pad_drive.sv
module pg_pad_drive
  import pg_pkg::*;
(
  input  logic      asserted,
  input  out_mode_t mode,
  output logic      level,
  output logic      oe
);
  assign level = pad_level(mode.pol_high, asserted);
  assign oe    = pad_enable(mode.push_pull, asserted);
endmodule

// File: rtl/pg_expiry_pulse.sv
module pg_expiry_pulse
  import pg_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int WIDTH_BITS  = 20,
  parameter int RESET_WIDTH = 255
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [DATA_W-1:0] cfg_wr_data,
  output logic [DATA_W-1:0] cfg_rd_data,
  input  logic              tick_1us,
  input  logic              expire,
  output logic              rst_level,
  output logic              rst_oe
);
  logic [WIDTH_BITS-1:0] width_q;
  out_mode_t             mode_q;
  logic                  pulse_on;
  logic                  pend_on;
  logic                  accept_evt;
  logic                  start_evt;
  logic                  end_evt;

  pg_cfg_reg #(
    .DATA_W(DATA_W), .WIDTH_BITS(WIDTH_BITS), .RESET_WIDTH(RESET_WIDTH)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_data(cfg_wr_data),
    .width_q(width_q), .mode_q(mode_q), .rd_data(cfg_rd_data)
  );

  pg_pulse_timer #(.WIDTH_BITS(WIDTH_BITS)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick_1us), .expire(expire),
    .load_width(width_q), .active(pulse_on), .pending(pend_on),
    .accept_evt(accept_evt), .start_evt(start_evt), .end_evt(end_evt)
  );

  pg_pad_drive u_pad (
    .asserted(pulse_on), .mode(mode_q), .level(rst_level), .oe(rst_oe)
  );

endmodule

// File: rtl/pg_expiry_chk.sv
module pg_expiry_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       wr_en,
  input logic [7:0] key,
  input logic       pol,
  input logic       drv,
  input logic       active,
  input logic       pending,
  input logic       level,
  input logic       oe
);
  // R6
  start_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> ($past(tick) && $past(pending)));

  // R7
  end_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> $past(tick));

  // R8
  no_retrigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> !pending);

  // R10
  asserted_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (level == pol));

  // R10
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (level != pol));

  // R11
  open_drain_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!drv && !active) |-> !oe);

  // R11
  push_pull_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drv |-> oe);

  // R3
  pol_high_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && key == 8'hA5) |=> pol);

  // R4
  drv_open_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && key == 8'h8A) |=> !drv);

  // R5
  pol_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && key != 8'hA5 && key != 8'h5A) |=> $stable(pol));

  // R5
  drv_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && key != 8'hA8 && key != 8'h8A) |=> $stable(drv));
endmodule

bind pg_expiry_pulse pg_expiry_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick_1us), .wr_en(cfg_wr_en),
  .key(cfg_wr_data[31:24]), .pol(cfg_rd_data[31]), .drv(cfg_rd_data[30]),
  .active(pulse_on), .pending(pend_on), .level(rst_level), .oe(rst_oe)
);

// File: tb/tb_pg_expiry_pulse.sv
module tb_pg_expiry_pulse;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [31:0] cfg_wr_data = '0;
  logic [31:0] cfg_rd_data;
  logic        tick_1us = 1'b0;
  logic        expire = 1'b0;
  logic        rst_level, rst_oe;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;
  int tdiv    = 0;

  // behavioural reference state
  int m_width = 255, m_pol = 0, m_drv = 0, m_pend = 0, m_act = 0, m_rem = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pg_expiry_pulse dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data), .tick_1us(tick_1us), .expire(expire),
    .rst_level(rst_level), .rst_oe(rst_oe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // tick generator: one-cycle pulse every TICK_DIV clocks
  always @(posedge clk) begin
    #2;
    if (!rst_n) begin tdiv = 0; tick_1us = 1'b0; end
    else begin tdiv = (tdiv + 1) % TICK_DIV; tick_1us = (tdiv == 0); end
  end

  // reference model, updated from the inputs present at each edge
  always @(posedge clk) begin
    int o_act, o_pend, o_width;
    if (!rst_n) begin
      m_width = 255; m_pol = 0; m_drv = 0; m_pend = 0; m_act = 0; m_rem = 0;
    end else begin
      o_act = m_act; o_pend = m_pend; o_width = m_width;
      if (o_act && tick_1us) begin
        if (m_rem == 0) m_act = 0; else m_rem = m_rem - 1;
      end else if (o_pend && tick_1us) begin
        m_act = 1; m_rem = o_width; m_pend = 0;
      end
      if (expire && !o_act && !o_pend) m_pend = 1;
      if (cfg_wr_en) begin
        m_width = int'(cfg_wr_data[19:0]);
        case (cfg_wr_data[31:24])
          8'hA5: m_pol = 1;
          8'h5A: m_pol = 0;
          8'hA8: m_drv = 1;
          8'h8A: m_drv = 0;
          default: ;
        endcase
      end
    end
  end

  // cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R10 level vs model", {31'b0, rst_level}, m_act ? m_pol : (1 - m_pol));
      chk("R11 oe vs model", {31'b0, rst_oe}, (m_drv || m_act) ? 1 : 0);
      chk("R2 readback vs model", cfg_rd_data,
          (32'(m_pol) << 31) | (32'(m_drv) << 30) | 32'(m_width));
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic wr(input logic [31:0] d);
    cfg_wr_en = 1'b1; cfg_wr_data = d;
    step();
    cfg_wr_en = 1'b0;
  endtask

  // run one trigger, optional retrigger / width write; count asserted cycles
  task automatic run_pulse(input logic pol, input int retrig_at, input int wr_at,
                           input logic [31:0] wr_val, input int window, output int cyc);
    cyc = 0;
    for (int i = 0; i < window; i++) begin
      expire    = (i == 0) || (i == retrig_at);
      cfg_wr_en = (i == wr_at);
      cfg_wr_data = wr_val;
      @(negedge clk);
      if (rst_level == pol) cyc++;
      step();
    end
    expire = 1'b0; cfg_wr_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int cyc;
    repeat (3) step();
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset readback", cfg_rd_data, 32'h0000_00FF);
    chk("R1 reset oe", {31'b0, rst_oe}, 32'd0);
    chk("R1 reset level", {31'b0, rst_level}, 32'd1);
    step();

    // R2 width bits only, bits 29:20 read zero
    wr(32'h3FFA_BCDE); @(negedge clk);
    chk("R2 width store", cfg_rd_data, 32'h000A_BCDE);
    step();
    // R3 polarity keys
    wr(32'hA500_0003); @(negedge clk);
    chk("R3 key A5", cfg_rd_data, 32'h8000_0003);
    step();
    // R4 drive keys
    wr(32'hA800_0004); @(negedge clk);
    chk("R4 key A8", cfg_rd_data, 32'hC000_0004);
    chk("R11 push-pull idle oe", {31'b0, rst_oe}, 32'd1);
    chk("R10 active-high idle level", {31'b0, rst_level}, 32'd0);
    step();
    // R5 non-key top byte: modes kept, width written
    wr(32'h1200_0007); @(negedge clk);
    chk("R5 non-key keeps modes", cfg_rd_data, 32'hC000_0007);
    step();
    wr(32'hA400_0008); @(negedge clk);
    chk("R5 near-key A4 ignored", cfg_rd_data, 32'hC000_0008);
    step();
    wr(32'h5A00_0009); @(negedge clk);
    chk("R3 key 5A", cfg_rd_data, 32'h4000_0009);
    step();
    wr(32'h8A00_0002); @(negedge clk);
    chk("R4 key 8A", cfg_rd_data, 32'h0000_0002);
    chk("R11 open-drain idle oe", {31'b0, rst_oe}, 32'd0);
    step();

    // R6: edge sampling expire does not start the pulse at once
    expire = 1'b1; step(); expire = 1'b0;
    @(negedge clk);
    chk("R6 no start in trigger cycle", {31'b0, rst_level}, 32'd1);
    repeat (8 * TICK_DIV) step();

    // R7 lengths for N = 0, 2, 5 (active low, open drain)
    wr(32'h0000_0000);
    run_pulse(1'b0, -1, -1, 32'h0, 4 * TICK_DIV + 4, cyc);
    chk("R7 N=0 length", cyc, 1 * TICK_DIV);
    wr(32'h0000_0002);
    run_pulse(1'b0, -1, -1, 32'h0, 6 * TICK_DIV + 4, cyc);
    chk("R7 N=2 length", cyc, 3 * TICK_DIV);
    wr(32'hA500_0005);
    run_pulse(1'b1, -1, -1, 32'h0, 9 * TICK_DIV + 4, cyc);
    chk("R7 N=5 active-high length", cyc, 6 * TICK_DIV);

    // R8 retrigger during pulse ignored
    wr(32'h0000_0003);
    run_pulse(1'b1, 6, -1, 32'h0, 10 * TICK_DIV, cyc);
    chk("R8 retrigger ignored", cyc, 4 * TICK_DIV);
    // R8 retrigger while pending ignored
    run_pulse(1'b1, 1, -1, 32'h0, 10 * TICK_DIV, cyc);
    chk("R8 pending retrigger ignored", cyc, 4 * TICK_DIV);

    // R9 width write mid-pulse affects only the next pulse
    run_pulse(1'b1, -1, 7, 32'h0000_0001, 10 * TICK_DIV, cyc);
    chk("R9 captured width", cyc, 4 * TICK_DIV);
    run_pulse(1'b1, -1, -1, 32'h0, 6 * TICK_DIV, cyc);
    chk("R9 new width next pulse", cyc, 2 * TICK_DIV);

    // R11 push-pull pulse
    wr(32'hA800_0001);
    run_pulse(1'b1, -1, -1, 32'h0, 6 * TICK_DIV, cyc);
    chk("R11 push-pull pulse length", cyc, 2 * TICK_DIV);
    @(negedge clk);
    chk("R11 push-pull oe after pulse", {31'b0, rst_oe}, 32'd1);

    step();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule